// File: doc/BRIEF.md
# PWM Complementary Dead-Time Inserter

This block sits between a timer's PWM output and a pair of power-switch drivers. From one PWM waveform it makes a true drive signal and a complementary drive signal, and the two are never high together. Each time the input switches, the output that is turning off drops at once. The output that is turning on waits out a programmable dead interval first, so the high-side and low-side switches are never both conducting.

The dead interval can be set separately for each output. One byte of delay setting holds two nibbles. The upper nibble sets the turn-on delay of the true output and the lower nibble sets the turn-on delay of the complementary output. A 2-bit prescaler code stretches the count, so the delay runs in steps of 1, 2, 4 or 8 clock cycles. If the input switches again before a delay has run out, the pending turn-on is dropped and a new count starts for the new level.

Top module: `dt_inserter`

## Requirements
- R1: While reset is held and after it is released with `pwm_in` low, `drv_hi` is 0 and `drv_lo` is 1.
- R2: `drv_hi` and `drv_lo` are never 1 in the same cycle.
- R3: Let the first clock edge that samples `pwm_in` high after it was low be edge E. `drv_hi` becomes 1 at edge E + `dt_value[7:4]` × 2^`dt_presc`.
- R4: Let the first clock edge that samples `pwm_in` low after it was high be edge E. `drv_lo` becomes 1 at edge E + `dt_value[3:0]` × 2^`dt_presc`.
- R5: The output that was on turns off at the first clock edge that samples the opposite input level, with no delay.
- R6: While a dead interval is counting, both `drv_hi` and `drv_lo` are 0.
- R7: If the nibble that applies to the new level is zero, the newly active output turns on at the same edge that samples the new level.
- R8: `dt_presc` codes 0, 1, 2 and 3 multiply the nibble count by 1, 2, 4 and 8 clock cycles respectively.
- R9: If `pwm_in` switches again before a pending delay expires, the pending output never turns on. The delay restarts from the nibble that applies to the newest level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Raw PWM waveform |
| dt_presc | input | 2 | Dead-time prescaler code (step = 2^code cycles) |
| dt_value | input | 8 | [7:4] true-output turn-on delay, [3:0] complementary-output turn-on delay |
| drv_hi | output | 1 | Non-inverted drive |
| drv_lo | output | 1 | Inverted drive |

## Verification
The embedded properties check on every cycle that:
- an output turns off on the cycle after the opposite level is sampled;
- both outputs are low after any edge whose nibble is non-zero;
- a zero nibble gives an immediate hand-over;
- the counter steps down by exactly one per prescaler tick;
- ticks are spaced by the selected division.

The exact turn-on cycle for each nibble and prescaler code, the cancelled turn-on on a quick re-toggle, and the output values just after reset can only be shown by the bench's scenarios. The bench compares both outputs cycle by cycle against expected values computed from the nibbles and the code.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int FIELD_W = 4;
    localparam int PRESC_W = 2;
    localparam int MAX_SHIFT = (1 << PRESC_W) - 1;
    localparam int PCNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    typedef struct packed {
        logic hi;
        logic lo;
    } drive_t;

    // all-ones mask of width 'code': terminal value of the prescaler count
    function automatic logic [PCNT_W-1:0] presc_mask(input logic [PRESC_W-1:0] code);
        logic [PCNT_W:0] one_hot;
        one_hot = '0;
        one_hot[code] = 1'b1;
        return PCNT_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/dt_edge_track.sv
module dt_edge_track (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    output logic level,
    output logic edge_seen
);
    always_ff @(posedge clk) begin
        if (rst) level <= 1'b0;
        else     level <= pwm_in;
    end

    assign edge_seen = (pwm_in != level);
endmodule

// File: rtl/dt_prescaler.sv
module dt_prescaler
    import dt_pkg::*;
#(
    parameter int CODE_W = PRESC_W,
    localparam int CNT_W = PCNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] term;

    assign term = presc_mask(code);
    assign tick = (pcnt == term);

    always_ff @(posedge clk) begin
        if (rst || clr)  pcnt <= '0;
        else if (tick)   pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && term != '0) |=> (!tick || !$stable(code))); // R8
endmodule

// File: rtl/dt_delay_counter.sv
module dt_delay_counter #(
    parameter int CNT_W = dt_pkg::FIELD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R3
endmodule

// File: rtl/dt_inserter.sv
module dt_inserter
    import dt_pkg::*;
#(
    parameter int FIELD_W_P = FIELD_W,
    parameter int PRESC_W_P = PRESC_W,
    localparam int VALUE_W = 2 * FIELD_W_P
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwm_in,
    input  logic [PRESC_W_P-1:0] dt_presc,
    input  logic [VALUE_W-1:0]   dt_value,
    output logic                 drv_hi,
    output logic                 drv_lo
);
    logic                 level;
    logic                 edge_seen;
    logic                 tick;
    logic                 busy;
    logic [FIELD_W_P-1:0] delay_sel;
    drive_t               drv;

    // the nibble for the level being entered
    assign delay_sel = pwm_in ? dt_value[VALUE_W-1:FIELD_W_P] : dt_value[FIELD_W_P-1:0];

    dt_edge_track u_edge (
        .clk       (clk),
        .rst       (rst),
        .pwm_in    (pwm_in),
        .level     (level),
        .edge_seen (edge_seen)
    );

    dt_prescaler #(.CODE_W(PRESC_W_P)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .clr  (edge_seen),
        .code (dt_presc),
        .tick (tick)
    );

    dt_delay_counter #(.CNT_W(FIELD_W_P)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (edge_seen),
        .load_val (delay_sel),
        .tick     (tick),
        .busy     (busy)
    );

    always_comb begin
        drv.hi = level && !busy;
        drv.lo = !level && !busy;
    end

    assign drv_hi = drv.hi;
    assign drv_lo = drv.lo;

    AST_FALL_HI: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && !pwm_in) |=> !drv_hi); // R5
    AST_FALL_LO: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && pwm_in) |=> !drv_lo); // R5
    AST_DEAD_LOW: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && delay_sel != '0) |=> (!drv_hi && !drv_lo)); // R6
    AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && delay_sel == '0) |=> (drv_hi == $past(pwm_in) && drv_lo == !$past(pwm_in))); // R7
endmodule

// File: tb/tb_dt_inserter.sv
module tb_dt_inserter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic [1:0] dt_presc = 2'd0;
    logic [7:0] dt_value = 8'h00;
    logic       drv_hi;
    logic       drv_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  hi;
        logic  lo;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    dt_inserter dut (
        .clk      (clk),
        .rst      (rst),
        .pwm_in   (pwm_in),
        .dt_presc (dt_presc),
        .dt_value (dt_value),
        .drv_hi   (drv_hi),
        .drv_lo   (drv_lo)
    );

    task automatic check(input logic act_hi, input logic act_lo,
                         input logic e_hi, input logic e_lo, input string tag);
        checks++;
        if (act_hi !== e_hi || act_lo !== e_lo) begin
            fails++;
            $display("FAIL %s: hi/lo actual %b%b expected %b%b at %0t",
                     tag, act_hi, act_lo, e_hi, e_lo, $time);
        end
    endtask

    // driver: applies one input level and queues the expected outputs
    task automatic drive(input logic lvl, input logic [7:0] dtv, input logic [1:0] ps,
                         input int hold, input string tag);
        int f;
        int d;
        @(negedge clk);
        pwm_in   = lvl;
        dt_value = dtv;
        dt_presc = ps;
        f = lvl ? int'(dtv[7:4]) : int'(dtv[3:0]);
        d = f << ps;
        for (int j = 1; j <= hold; j++) begin
            exp_t e;
            e.hi  = lvl && ((j - 1) >= d);
            e.lo  = !lvl && ((j - 1) >= d);
            e.tag = tag;
            sb.push_back(e);
        end
        repeat (hold - 1) @(negedge clk);
    endtask

    // monitor: compares one queued item per cycle, away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(drv_hi, drv_lo, e.hi, e.lo, e.tag);
                check(drv_hi && drv_lo, 1'b0, 1'b0, 1'b0, "R2 overlap");
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        @(posedge clk);
        #5;
        check(drv_hi, drv_lo, 1'b0, 1'b1, "R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        check(drv_hi, drv_lo, 1'b0, 1'b1, "R1 after reset");

        drive(1'b1, 8'h32, 2'd0, 6,  "R3 R6");
        drive(1'b0, 8'h32, 2'd0, 5,  "R4 R5 R6");
        drive(1'b1, 8'h21, 2'd1, 7,  "R8 x2 R3");
        drive(1'b0, 8'h21, 2'd2, 7,  "R8 x4 R4");
        drive(1'b1, 8'h10, 2'd3, 10, "R8 x8 R5");
        drive(1'b0, 8'h10, 2'd0, 3,  "R7 lo");
        drive(1'b1, 8'h00, 2'd0, 3,  "R7 hi");
        drive(1'b0, 8'h05, 2'd0, 3,  "R9 abort lo");
        drive(1'b1, 8'h50, 2'd0, 2,  "R9 abort hi");
        drive(1'b0, 8'h53, 2'd0, 6,  "R9 restart");

        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule